// File: doc/BRIEF.md
# Interlaced PAL Raster Timing Generator

This block produces the raster timing for a 720 by 576 interlaced picture at 50 fields per second. It advances one sample on every clock cycle where the 13.5 MHz sample enable is high. From a sample counter and a frame line counter it decodes active-low horizontal and vertical sync, horizontal and vertical blanking, a field flag and a data-enable. It also presents the current sample and line numbers so that an upstream pixel source knows which pixel of which field to supply next.

A frame holds 625 lines, numbered from 1, and each line holds 864 samples. Line 1 starts the first field. Line 313, which is (625+1)/2, starts the second field. Vertical sync in the second field starts half a line later than in the first, so each field carries exactly one sync pulse and the pulses are 312.5 lines apart. All outputs are plain level signals with no handshake: the timing never stalls, and the pixel source has to keep pace with the data-enable. Every count is a parameter, and the defaults give the PAL geometry.

Top module: `pal_raster_gen`

## Requirements
- R1: `pix_x` counts 0 to 863 and wraps to 0. On each wrap `line_y` steps by one through 1 to 625, and after 625 it returns to 1. Both change only on cycles where `pix_en` is 1.
- R2: `hblank` is 1 for samples 720 to 863 and 0 for samples 0 to 719. `hsync_n` is 0 for samples 742 to 804 inclusive and 1 for all other samples.
- R3: `field` is 0 on lines 1 to 312 and 1 on lines 313 to 625. It therefore rises on entering line 313 and falls on entering line 1.
- R4: `vblank` is 0 on lines 23 to 310 (first field) and on lines 336 to 623 (second field). It is 1 on all other lines.
- R5: In the first field, `vsync_n` is 0 from sample 0 of line 1 through the last sample of line 5.
- R6: In the second field, `vsync_n` is 0 from sample 432 of line 313 through sample 431 of line 318, that is, half a line offset from the first field. It is 1 everywhere outside R5 and R6, so exactly one falling edge of `vsync_n` occurs per field.
- R7: `de` is 1 exactly when `hblank` and `vblank` are both 0, which gives 288 lines of 720 samples per field.
- R8: While the synchronous reset `rst` is 1, the counters go to sample 0 of line 1 and `pix_en` is ignored.
- R9: On a cycle where `pix_en` is 0, the counters hold and every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Sample enable, one pulse per 13.5 MHz sample |
| pix_x | output | 10 | Current sample within the line |
| line_y | output | 10 | Current frame line, 1 to 625 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field | output | 1 | 0 in the first field, 1 in the second |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| de | output | 1 | Active picture sample |

## Verification
The bench targets the second-field sync offset. A design that started or ended that pulse on a whole line would drift toward 60 Hz-like cadences or lose every other sync pulse, and the bench counts falling edges of `vsync_n` per field to expose it. It also targets the asymmetric blanking, 24 lines around the first field and 25 around the second. If that split were wrong, a field would carry 287 or 289 active lines, which the per-field data-enable count catches. A scaled-down instance runs many full frames to cover frame wrap and field toggling, the default instance is checked over its first lines, and stalls of `pix_en` and a mid-run reset confirm that nothing moves without an enable.

// File: rtl/pal_raster_pkg.sv
package pal_raster_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE,
    PH_FRONT,
    PH_SYNC,
    PH_BACK
  } h_phase_e;
endpackage

// File: rtl/pal_line_timer.sv
module pal_line_timer
  import pal_raster_pkg::*;
#(
  parameter int H_ACTIVE = 720,
  parameter int H_FP     = 22,
  parameter int H_SYNC   = 63,
  parameter int H_BP     = 59,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  output logic [CNT_W-1:0] pix_x,
  output logic             hblank,
  output logic             hsync_n,
  output logic             line_step,
  output logic             past_half
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam logic [CNT_W-1:0] X_LAST   = CNT_W'(H_TOTAL - 1);
  localparam logic [CNT_W-1:0] X_ACT    = CNT_W'(H_ACTIVE);
  localparam logic [CNT_W-1:0] X_SYNC_B = CNT_W'(H_ACTIVE + H_FP);
  localparam logic [CNT_W-1:0] X_SYNC_E = CNT_W'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [CNT_W-1:0] X_HALF   = CNT_W'(H_TOTAL / 2);

  h_phase_e phase;

  // sample counter
  always_ff @(posedge clk) begin
    if (rst)            pix_x <= '0;
    else if (line_step) pix_x <= '0;
    else if (pix_en)    pix_x <= pix_x + 1'b1;
  end

  assign line_step = pix_en && (pix_x == X_LAST);
  assign past_half = (pix_x >= X_HALF);

  always_comb begin
    if (pix_x < X_ACT)         phase = PH_ACTIVE;
    else if (pix_x < X_SYNC_B) phase = PH_FRONT;
    else if (pix_x < X_SYNC_E) phase = PH_SYNC;
    else                       phase = PH_BACK;
  end

  assign hblank  = (phase != PH_ACTIVE);
  assign hsync_n = (phase != PH_SYNC);

  AST_X_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_step |=> (pix_x == '0)); // R1
  AST_X_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(pix_x)); // R9
  AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> hblank); // R2
endmodule

// File: rtl/pal_frame_timer.sv
module pal_frame_timer #(
  parameter int V_LINES      = 625,
  parameter int ACT_LINES    = 288,
  parameter int F1_ACT_START = 23,
  parameter int V_SYNC_LINES = 5,
  parameter int CNT_W        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_step,
  input  logic             past_half,
  output logic [CNT_W-1:0] line_y,
  output logic             field,
  output logic             vblank,
  output logic             vsync_n
);
  localparam int F_RISE_I   = (V_LINES + 1) / 2;
  localparam int F2_START_I = F1_ACT_START + ACT_LINES + (V_LINES - 2 * ACT_LINES + 1) / 2;
  localparam logic [CNT_W-1:0] Y_LAST   = CNT_W'(V_LINES);
  localparam logic [CNT_W-1:0] Y_FIRST  = CNT_W'(1);
  localparam logic [CNT_W-1:0] F_RISE   = CNT_W'(F_RISE_I);
  localparam logic [CNT_W-1:0] A1_BEG   = CNT_W'(F1_ACT_START);
  localparam logic [CNT_W-1:0] A1_END   = CNT_W'(F1_ACT_START + ACT_LINES - 1);
  localparam logic [CNT_W-1:0] A2_BEG   = CNT_W'(F2_START_I);
  localparam logic [CNT_W-1:0] A2_END   = CNT_W'(F2_START_I + ACT_LINES - 1);
  localparam logic [CNT_W-1:0] VS0_END  = CNT_W'(V_SYNC_LINES);
  localparam logic [CNT_W-1:0] VS1_LAST = CNT_W'(F_RISE_I + V_SYNC_LINES);

  logic vs_first, vs_second, act_line;

  // frame line counter, lines numbered from 1
  always_ff @(posedge clk) begin
    if (rst)            line_y <= Y_FIRST;
    else if (line_step) line_y <= (line_y == Y_LAST) ? Y_FIRST : line_y + 1'b1;
  end

  assign field = (line_y >= F_RISE);

  assign act_line = ((line_y >= A1_BEG) && (line_y <= A1_END)) ||
                    ((line_y >= A2_BEG) && (line_y <= A2_END));
  assign vblank = !act_line;

  // first field: whole lines; second field: shifted by half a line
  assign vs_first  = (line_y <= VS0_END);
  assign vs_second = ((line_y == F_RISE) && past_half) ||
                     ((line_y > F_RISE) && (line_y < VS1_LAST)) ||
                     ((line_y == VS1_LAST) && !past_half);
  assign vsync_n = !(vs_first || vs_second);

  AST_Y_RANGE: assert property (@(posedge clk) disable iff (rst)
    (line_y >= Y_FIRST) && (line_y <= Y_LAST)); // R1
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_step |=> $stable(line_y)); // R9
  AST_FIELD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(field) |-> (line_y == F_RISE)); // R3
  AST_FIELD_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(field) |-> (line_y == Y_FIRST)); // R3
  AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> vblank); // R6
endmodule

// File: rtl/pal_raster_gen.sv
module pal_raster_gen #(
  parameter int H_ACTIVE     = 720,
  parameter int H_FP         = 22,
  parameter int H_SYNC       = 63,
  parameter int H_BP         = 59,
  parameter int V_LINES      = 625,
  parameter int ACT_LINES    = 288,
  parameter int F1_ACT_START = 23,
  parameter int V_SYNC_LINES = 5,
  parameter int CNT_W        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             field,
  output logic             hblank,
  output logic             vblank,
  output logic             de
);
  logic line_step, past_half;

  pal_line_timer #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .CNT_W(CNT_W)
  ) u_line (
    .clk(clk), .rst(rst), .pix_en(pix_en), .pix_x(pix_x), .hblank(hblank),
    .hsync_n(hsync_n), .line_step(line_step), .past_half(past_half)
  );

  pal_frame_timer #(
    .V_LINES(V_LINES), .ACT_LINES(ACT_LINES), .F1_ACT_START(F1_ACT_START),
    .V_SYNC_LINES(V_SYNC_LINES), .CNT_W(CNT_W)
  ) u_frame (
    .clk(clk), .rst(rst), .line_step(line_step), .past_half(past_half),
    .line_y(line_y), .field(field), .vblank(vblank), .vsync_n(vsync_n)
  );

  assign de = !hblank && !vblank;

  AST_DE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(de)); // R9
  AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n)); // R7
endmodule

// File: tb/pal_raster_gen_bench.sv
module pal_raster_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en_b, en_s, chk_on;
  int nchk = 0, nfail = 0;

  logic [9:0] bx_o, by_o, sx_o, sy_o;
  logic bhs, bvs, bfl, bhb, bvb, bde;
  logic shs, svs, sfl, shb, svb, sde;

  pal_raster_gen u_pal_raster_gen (
    .clk(clk), .rst(rst), .pix_en(en_b), .pix_x(bx_o), .line_y(by_o),
    .hsync_n(bhs), .vsync_n(bvs), .field(bfl), .hblank(bhb), .vblank(bvb), .de(bde)
  );

  pal_raster_gen #(
    .H_ACTIVE(16), .H_FP(2), .H_SYNC(4), .H_BP(2), .V_LINES(25),
    .ACT_LINES(8), .F1_ACT_START(4), .V_SYNC_LINES(2)
  ) u_small (
    .clk(clk), .rst(rst), .pix_en(en_s), .pix_x(sx_o), .line_y(sy_o),
    .hsync_n(shs), .vsync_n(svs), .field(sfl), .hblank(shb), .vblank(svb), .de(sde)
  );

  task automatic chk(input string what, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // behavioural reference: returns {hsync_n, vsync_n, field, hblank, vblank, de}
  function automatic logic [5:0] ref_out(int x, int y, int ha, int hf, int hs, int hb,
                                          int vl, int al, int fa, int vs);
    int tot, fr, t, t1, rel;
    logic hsn, vsn, fld, hbl, vbl;
    tot = ha + hf + hs + hb;
    fr  = (vl + 1) / 2;
    hbl = (x >= ha);
    hsn = !((x >= ha + hf) && (x < ha + hf + hs));
    fld = (y >= fr);
    rel = fld ? (y - (fr + fa)) : (y - fa);
    vbl = !((rel >= 0) && (rel < al));
    t   = 2 * (y - 1) + ((x >= tot / 2) ? 1 : 0);
    t1  = 2 * (fr - 1) + 1;
    vsn = !((t < 2 * vs) || ((t >= t1) && (t < t1 + 2 * vs)));
    return {hsn, vsn, fld, hbl, vbl, (!hbl && !vbl)};
  endfunction

  int mbx, mby, msx, msy;
  always @(posedge clk) begin
    if (rst) begin
      mbx <= 0; mby <= 1; msx <= 0; msy <= 1;
    end else begin
      if (en_b) begin
        if (mbx == 863) begin mbx <= 0; mby <= (mby == 625) ? 1 : mby + 1; end
        else mbx <= mbx + 1;
      end
      if (en_s) begin
        if (msx == 23) begin msx <= 0; msy <= (msy == 25) ? 1 : msy + 1; end
        else msx <= msx + 1;
      end
    end
  end

  task automatic cmp_all(input string tag, input int mx, input int my, input logic [5:0] e,
                         input logic [9:0] ax, input logic [9:0] ay,
                         input logic hs, input logic vs, input logic fl,
                         input logic hb, input logic vb, input logic d);
    chk({tag, " pix_x"}, "R1/R9", ax, mx);
    chk({tag, " line_y"}, "R1/R9", ay, my);
    chk({tag, " hsync_n"}, "R2", hs, e[5]);
    chk({tag, " vsync_n"}, "R5/R6", vs, e[4]);
    chk({tag, " field"}, "R3", fl, e[3]);
    chk({tag, " hblank"}, "R2", hb, e[2]);
    chk({tag, " vblank"}, "R4", vb, e[1]);
    chk({tag, " de"}, "R7", d, e[0]);
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      cmp_all("big", mbx, mby, ref_out(mbx, mby, 720, 22, 63, 59, 625, 288, 23, 5),
              bx_o, by_o, bhs, bvs, bfl, bhb, bvb, bde);
      cmp_all("small", msx, msy, ref_out(msx, msy, 16, 2, 4, 2, 25, 8, 4, 2),
              sx_o, sy_o, shs, svs, sfl, shb, svb, sde);
    end
  end

  // per-field totals on the scaled instance: R6 one vsync edge, R7 active samples
  logic pf, pvs, started;
  int de_cnt, vs_falls;
  always @(negedge clk) begin
    if (!chk_on || rst) begin
      started <= 1'b0; pf <= 1'b0; pvs <= 1'b1; de_cnt <= 0; vs_falls <= 0;
    end else begin
      if (sfl !== pf) begin
        if (started) begin
          chk("field vsync falls", "R6", vs_falls, 1);
          chk("field active samples", "R7", de_cnt, 8 * 16);
        end
        started  <= 1'b1;
        de_cnt   <= (sde && en_s) ? 1 : 0;
        vs_falls <= (!svs && pvs) ? 1 : 0;
      end else begin
        if (sde && en_s) de_cnt <= de_cnt + 1;
        if (!svs && pvs) vs_falls <= vs_falls + 1;
      end
      pf  <= sfl;
      pvs <= svs;
    end
  end

  task automatic reset_check;
    rst = 1'b1; en_b = 1'b1; en_s = 1'b1;   // R8: enable must be ignored
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset pix_x big", "R8", bx_o, 0);
    chk("reset line_y big", "R8", by_o, 1);
    chk("reset pix_x small", "R8", sx_o, 0);
    chk("reset line_y small", "R8", sy_o, 1);
    chk("reset hsync_n", "R8", bhs, 1);
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      en_b = ($urandom % 6) != 0;
      en_s = ($urandom % 5) != 0;
    end
  endtask

  initial begin
    chk_on = 1'b0; rst = 1'b1; en_b = 1'b0; en_s = 1'b0;
    reset_check();
    chk_on = 1'b1;
    run(60000);
    reset_check();
    run(70000);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule